// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block computes post-modified addresses for circular buffers. Each register set describes one buffer with four words: a pointer (index), a signed step (modify), a buffer size (length) and a start address (base). A buffer may begin at any address and span any number of words, with no alignment requirement. Each access returns the pointer as it stood before the access. In the same cycle the block advances the pointer by the selected step and folds it back into the buffer window, so the wrap costs no extra instruction.

The block holds two complete copies of all register sets, a primary copy and a secondary copy. A mode bit chooses which copy is live, so an interrupt handler can switch to its own buffers in a single cycle without saving the interrupted ones. Two generators run side by side, and each owns its own half of the register sets. Two addresses can therefore be produced in the same cycle. Software loads registers through one write port that addresses all sets by a global set number.

Top module: `cbuf_agen`

## Requirements
- R1: After reset every register in both copies reads as zero, and `addr_vld_o` and `addr_o` are zero. An access made before any write therefore returns address 0.
- R2: An access issued on generator g in cycle n gives `addr_vld_o[g]`=1 and the pre-modify pointer on `addr_o` in cycle n+1. Without an access, `addr_vld_o[g]` is 0 and `addr_o` holds its last value.
- R3: With a nonzero length, when pointer + step is at or above base + length, the new pointer is that sum minus the length.
- R4: With a nonzero length, when pointer + step is below base, the new pointer is that sum plus the length. The step is a two's-complement 32-bit value.
- R5: A length of zero turns off wrapping. The new pointer is pointer + step modulo 2^32.
- R6: A register write uses `wr_kind_i` as follows: 0 writes the pointer, 1 the step, 2 the length and 3 the base. Writing the base also loads the pointer of that set with the same value.
- R7: `bank_sel_i`=0 selects the primary copy and 1 selects the secondary copy. It applies to writes and accesses in the same cycle. The copy that is not selected keeps its contents.
- R8: Global set s belongs to generator s / 8, at local number s mod 8. `acc_buf_i[3g+2:3g]` picks generator g's buffer and `acc_mod_i[3g+2:3g]` picks which of its local sets supplies the step. Both generators can access in the same cycle without affecting each other.
- R9: When a write to the pointer or the base of a set lands in the same cycle as an access to that set, the access returns the old pointer and the written value wins.
- R10: Base and length take any value, with no alignment. A step whose magnitude is at most the length, applied to a pointer inside [base, base+length), yields a pointer inside that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bank_sel_i | input | 1 | Selects the register copy: 0 primary, 1 secondary |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Register kind: 0 pointer, 1 step, 2 length, 3 base |
| wr_set_i | input | 4 | Global set number of the write |
| wr_data_i | input | 32 | Write data |
| acc_vld_i | input | 2 | Access request, one bit per generator |
| acc_buf_i | input | 6 | Local buffer select, 3 bits per generator |
| acc_mod_i | input | 6 | Local step-register select, 3 bits per generator |
| addr_vld_o | output | 2 | Address valid, one bit per generator |
| addr_o | output | 64 | Pre-modify address, 32 bits per generator |

## Verification
The bench walks a pointer around an unaligned 7-word window three ways. It uses a small positive step, a negative step, and steps of exactly plus and minus the length, which separates the upper fold from the lower fold and tests the boundary. A zero-length set is stepped across the top of the 32-bit space in both directions to show linear, modulo-2^32 behaviour. Dual-generator traffic, a switch to the secondary copy and back, and a write colliding with an access show that the copies, the generators and the write priority stay separate.

// File: rtl/cbuf_agen_pkg.sv
package cbuf_agen_pkg;

   // Register kinds addressed by the write port
   typedef enum logic [1:0] {
      KIND_PTR  = 2'd0,
      KIND_STEP = 2'd1,
      KIND_LEN  = 2'd2,
      KIND_BASE = 2'd3
   } reg_kind_e;

   localparam int NUM_COPIES = 2;

endpackage

// File: rtl/cbuf_wrap.sv
// Post-modify with fold-back into [base, base+len); len == 0 means linear.
module cbuf_wrap #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] idx_i,
   input  logic [AW-1:0] step_i,
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] len_i,
   output logic [AW-1:0] nxt_o
);
   localparam int EW = AW + 2;

   logic signed [EW-1:0] sum_s;
   logic signed [EW-1:0] lo_s;
   logic signed [EW-1:0] hi_s;
   logic signed [EW-1:0] len_s;
   logic signed [EW-1:0] res_s;

   always_comb begin
      sum_s = $signed({2'b00, idx_i}) + $signed({{2{step_i[AW-1]}}, step_i});
      lo_s  = $signed({2'b00, base_i});
      len_s = $signed({2'b00, len_i});
      hi_s  = lo_s + len_s;
      if (len_i == '0)
         res_s = sum_s;
      else if (sum_s >= hi_s)
         res_s = sum_s - len_s;
      else if (sum_s < lo_s)
         res_s = sum_s + len_s;
      else
         res_s = sum_s;
      nxt_o = res_s[AW-1:0];
   end

endmodule

// File: rtl/cbuf_regbank.sv
// Register sets owned by one generator, in both copies.
module cbuf_regbank
   import cbuf_agen_pkg::*;
#(
   parameter int AW   = 32,
   parameter int SETS = 8,
   localparam int SW  = $clog2(SETS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bank_i,
   input  logic          wr_en_i,
   input  reg_kind_e     wr_kind_i,
   input  logic [SW-1:0] wr_set_i,
   input  logic [AW-1:0] wr_data_i,
   input  logic          upd_en_i,
   input  logic [SW-1:0] upd_set_i,
   input  logic [AW-1:0] upd_val_i,
   input  logic [SW-1:0] rd_set_i,
   input  logic [SW-1:0] rd_step_sel_i,
   output logic [AW-1:0] rd_idx_o,
   output logic [AW-1:0] rd_base_o,
   output logic [AW-1:0] rd_len_o,
   output logic [AW-1:0] rd_step_o
);
   localparam int TOTAL = NUM_COPIES * SETS;

   logic [AW-1:0] idx_a  [TOTAL];
   logic [AW-1:0] step_a [TOTAL];
   logic [AW-1:0] len_a  [TOTAL];
   logic [AW-1:0] base_a [TOTAL];

   for (genvar bk = 0; bk < NUM_COPIES; bk++) begin : g_copy
      for (genvar s = 0; s < SETS; s++) begin : g_set
         logic          live;
         logic          wr_hit;
         logic          upd_hit;
         logic [AW-1:0] idx_r;
         logic [AW-1:0] step_r;
         logic [AW-1:0] len_r;
         logic [AW-1:0] base_r;

         assign live    = (bank_i == 1'(bk));
         assign wr_hit  = live && wr_en_i  && (wr_set_i  == SW'(s));
         assign upd_hit = live && upd_en_i && (upd_set_i == SW'(s));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx_r  <= '0;
               step_r <= '0;
               len_r  <= '0;
               base_r <= '0;
            end else begin
               if (upd_hit)
                  idx_r <= upd_val_i;
               if (wr_hit) begin
                  unique case (wr_kind_i)
                     KIND_PTR:  idx_r  <= wr_data_i;
                     KIND_STEP: step_r <= wr_data_i;
                     KIND_LEN:  len_r  <= wr_data_i;
                     KIND_BASE: begin
                        base_r <= wr_data_i;
                        idx_r  <= wr_data_i;
                     end
                     default: ;
                  endcase
               end
            end
         end

         assign idx_a [bk*SETS + s] = idx_r;
         assign step_a[bk*SETS + s] = step_r;
         assign len_a [bk*SETS + s] = len_r;
         assign base_a[bk*SETS + s] = base_r;
      end
   end

   always_comb begin
      rd_idx_o  = idx_a [int'(bank_i) * SETS + int'(rd_set_i)];
      rd_base_o = base_a[int'(bank_i) * SETS + int'(rd_set_i)];
      rd_len_o  = len_a [int'(bank_i) * SETS + int'(rd_set_i)];
      rd_step_o = step_a[int'(bank_i) * SETS + int'(rd_step_sel_i)];
   end

endmodule

// File: rtl/cbuf_agen_chk.sv
module cbuf_agen_chk #(
   parameter int AW      = 32,
   parameter int NUM_GEN = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_GEN-1:0]    acc_vld_i,
   input logic [NUM_GEN-1:0]    addr_vld_o,
   input logic [NUM_GEN*AW-1:0] addr_o,
   input logic [AW-1:0]         cur_idx  [NUM_GEN],
   input logic [AW-1:0]         cur_base [NUM_GEN],
   input logic [AW-1:0]         cur_len  [NUM_GEN],
   input logic [AW-1:0]         cur_step [NUM_GEN],
   input logic [AW-1:0]         nxt_idx  [NUM_GEN]
);
   function automatic bit in_win(logic [AW-1:0] v, logic [AW-1:0] b, logic [AW-1:0] l);
      logic [AW:0] hi;
      hi = {1'b0, b} + {1'b0, l};
      return ({1'b0, v} >= {1'b0, b}) && ({1'b0, v} < hi);
   endfunction

   function automatic bit step_fits(logic [AW-1:0] m, logic [AW-1:0] l);
      logic [AW-1:0] mag;
      mag = m[AW-1] ? (~m + 1'b1) : m;
      return mag <= l;
   endfunction

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (addr_vld_o == '0));

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
      // R2
      issue_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         acc_vld_i[g] |=> addr_vld_o[g]);
      // R2
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !acc_vld_i[g] |=> (!addr_vld_o[g] && $stable(addr_o[g*AW +: AW])));
      // R10
      stay_in_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_vld_i[g] && cur_len[g] != '0 && in_win(cur_idx[g], cur_base[g], cur_len[g])
          && step_fits(cur_step[g], cur_len[g]))
         |-> in_win(nxt_idx[g], cur_base[g], cur_len[g]));
      // R5
      linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_vld_i[g] && cur_len[g] == '0) |-> (nxt_idx[g] == cur_idx[g] + cur_step[g]));
   end

endmodule

// File: rtl/cbuf_agen.sv
module cbuf_agen
   import cbuf_agen_pkg::*;
#(
   parameter int AW       = 32,
   parameter int NUM_SETS = 16,
   parameter int NUM_GEN  = 2,
   localparam int SETS_PER_GEN = NUM_SETS / NUM_GEN,
   localparam int LSW          = $clog2(SETS_PER_GEN),
   localparam int GSW          = $clog2(NUM_SETS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bank_sel_i,
   input  logic                   wr_en_i,
   input  logic [1:0]             wr_kind_i,
   input  logic [GSW-1:0]         wr_set_i,
   input  logic [AW-1:0]          wr_data_i,
   input  logic [NUM_GEN-1:0]     acc_vld_i,
   input  logic [NUM_GEN*LSW-1:0] acc_buf_i,
   input  logic [NUM_GEN*LSW-1:0] acc_mod_i,
   output logic [NUM_GEN-1:0]     addr_vld_o,
   output logic [NUM_GEN*AW-1:0]  addr_o
);
   // Elaboration-time parameter checks
   if (AW < 8) begin : g_bad_aw
      $error("cbuf_agen: AW must be at least 8");
   end
   if (NUM_GEN < 1 || (NUM_SETS % NUM_GEN) != 0) begin : g_bad_split
      $error("cbuf_agen: NUM_SETS must divide evenly among NUM_GEN generators");
   end
   if (SETS_PER_GEN < 2 || (SETS_PER_GEN & (SETS_PER_GEN - 1)) != 0) begin : g_bad_sets
      $error("cbuf_agen: sets per generator must be a power of two, at least 2");
   end

   reg_kind_e wr_kind;
   assign wr_kind = reg_kind_e'(wr_kind_i);

   logic [AW-1:0] cur_idx  [NUM_GEN];
   logic [AW-1:0] cur_base [NUM_GEN];
   logic [AW-1:0] cur_len  [NUM_GEN];
   logic [AW-1:0] cur_step [NUM_GEN];
   logic [AW-1:0] nxt_idx  [NUM_GEN];

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      logic [LSW-1:0] buf_sel;
      logic [LSW-1:0] step_sel;
      logic           wr_mine;
      logic [AW-1:0]  addr_q;
      logic           vld_q;

      assign buf_sel  = acc_buf_i[g*LSW +: LSW];
      assign step_sel = acc_mod_i[g*LSW +: LSW];
      assign wr_mine  = wr_en_i && ((int'(wr_set_i) / SETS_PER_GEN) == g);

      cbuf_regbank #(
         .AW   (AW),
         .SETS (SETS_PER_GEN)
      ) regs_i (
         .clk           (clk),
         .rst_n         (rst_n),
         .bank_i        (bank_sel_i),
         .wr_en_i       (wr_mine),
         .wr_kind_i     (wr_kind),
         .wr_set_i      (wr_set_i[LSW-1:0]),
         .wr_data_i     (wr_data_i),
         .upd_en_i      (acc_vld_i[g]),
         .upd_set_i     (buf_sel),
         .upd_val_i     (nxt_idx[g]),
         .rd_set_i      (buf_sel),
         .rd_step_sel_i (step_sel),
         .rd_idx_o      (cur_idx[g]),
         .rd_base_o     (cur_base[g]),
         .rd_len_o      (cur_len[g]),
         .rd_step_o     (cur_step[g])
      );

      cbuf_wrap #(
         .AW (AW)
      ) wrap_i (
         .idx_i  (cur_idx[g]),
         .step_i (cur_step[g]),
         .base_i (cur_base[g]),
         .len_i  (cur_len[g]),
         .nxt_o  (nxt_idx[g])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q <= '0;
            vld_q  <= 1'b0;
         end else begin
            vld_q <= acc_vld_i[g];
            if (acc_vld_i[g])
               addr_q <= cur_idx[g];
         end
      end

      assign addr_vld_o[g]        = vld_q;
      assign addr_o[g*AW +: AW]   = addr_q;
   end

endmodule

bind cbuf_agen cbuf_agen_chk #(
   .AW      (AW),
   .NUM_GEN (NUM_GEN)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_vld_i  (acc_vld_i),
   .addr_vld_o (addr_vld_o),
   .addr_o     (addr_o),
   .cur_idx    (cur_idx),
   .cur_base   (cur_base),
   .cur_len    (cur_len),
   .cur_step   (cur_step),
   .nxt_idx    (nxt_idx)
);

// File: tb/cbuf_agen_tb_top.sv
`timescale 1ns/1ps
module cbuf_agen_tb_top;
   localparam int AW  = 32;
   localparam int NS  = 16;
   localparam int NG  = 2;
   localparam int SPG = 8;
   localparam int LSW = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             bank_sel_i = 1'b0;
   logic             wr_en_i = 1'b0;
   logic [1:0]       wr_kind_i = '0;
   logic [3:0]       wr_set_i = '0;
   logic [AW-1:0]    wr_data_i = '0;
   logic [NG-1:0]    acc_vld_i = '0;
   logic [NG*LSW-1:0] acc_buf_i = '0;
   logic [NG*LSW-1:0] acc_mod_i = '0;
   logic [NG-1:0]    addr_vld_o;
   logic [NG*AW-1:0] addr_o;

   cbuf_agen dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank_sel_i (bank_sel_i),
      .wr_en_i    (wr_en_i),
      .wr_kind_i  (wr_kind_i),
      .wr_set_i   (wr_set_i),
      .wr_data_i  (wr_data_i),
      .acc_vld_i  (acc_vld_i),
      .acc_buf_i  (acc_buf_i),
      .acc_mod_i  (acc_mod_i),
      .addr_vld_o (addr_vld_o),
      .addr_o     (addr_o)
   );

   int    total = 0;
   int    bad   = 0;
   string req   = "R1";

   // Reference state: [copy][global set]
   logic [31:0] m_idx  [2][NS];
   logic [31:0] m_step [2][NS];
   logic [31:0] m_len  [2][NS];
   logic [31:0] m_base [2][NS];
   logic [31:0] e_addr [NG];
   logic        e_vld  [NG];

   function automatic logic [31:0] ref_next(logic [31:0] i, logic [31:0] m,
                                           logic [31:0] b, logic [31:0] l);
      longint s;
      s = longint'(i) + longint'($signed(m));
      if (l == 0) return s[31:0];
      if (s >= longint'(b) + longint'(l)) s = s - longint'(l);
      else if (s < longint'(b)) s = s + longint'(l);
      return s[31:0];
   endfunction

   task automatic model_edge();
      int bk;
      bk = int'(bank_sel_i);
      for (int g = 0; g < NG; g++) begin
         if (acc_vld_i[g]) begin
            int s;
            int ms;
            s  = g*SPG + int'(acc_buf_i[g*LSW +: LSW]);
            ms = g*SPG + int'(acc_mod_i[g*LSW +: LSW]);
            e_addr[g]    = m_idx[bk][s];
            m_idx[bk][s] = ref_next(m_idx[bk][s], m_step[bk][ms], m_base[bk][s], m_len[bk][s]);
            e_vld[g]     = 1'b1;
         end else begin
            e_vld[g] = 1'b0;
         end
      end
      if (wr_en_i) begin
         int ws;
         ws = int'(wr_set_i);
         case (wr_kind_i)
            2'd0: m_idx[bk][ws]  = wr_data_i;
            2'd1: m_step[bk][ws] = wr_data_i;
            2'd2: m_len[bk][ws]  = wr_data_i;
            default: begin
               m_base[bk][ws] = wr_data_i;
               m_idx[bk][ws]  = wr_data_i;
            end
         endcase
      end
   endtask

   task automatic compare();
      for (int g = 0; g < NG; g++) begin
         total++;
         if (addr_vld_o[g] !== e_vld[g]) begin
            bad++;
            $display("FAIL %s gen%0d valid: actual=%0b expected=%0b", req, g, addr_vld_o[g], e_vld[g]);
         end
         total++;
         if (addr_o[g*AW +: AW] !== e_addr[g]) begin
            bad++;
            $display("FAIL %s gen%0d addr: actual=%h expected=%h", req, g, addr_o[g*AW +: AW], e_addr[g]);
         end
      end
   endtask

   task automatic cycle();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
      wr_en_i   = 1'b0;
      acc_vld_i = '0;
   endtask

   task automatic set_wr(int s, int kind, logic [31:0] d);
      wr_en_i   = 1'b1;
      wr_set_i  = 4'(s);
      wr_kind_i = 2'(kind);
      wr_data_i = d;
   endtask

   task automatic set_acc(int g, int b, int m);
      acc_vld_i[g]            = 1'b1;
      acc_buf_i[g*LSW +: LSW] = 3'(b);
      acc_mod_i[g*LSW +: LSW] = 3'(m);
   endtask

   task automatic wr(int s, int kind, logic [31:0] d);
      set_wr(s, kind, d);
      cycle();
   endtask

   task automatic acc0(int b, int m, int n);
      for (int k = 0; k < n; k++) begin
         set_acc(0, b, m);
         cycle();
      end
   endtask

   initial begin
      for (int c = 0; c < 2; c++)
         for (int s = 0; s < NS; s++) begin
            m_idx[c][s] = '0; m_step[c][s] = '0; m_len[c][s] = '0; m_base[c][s] = '0;
         end
      for (int g = 0; g < NG; g++) begin
         e_addr[g] = '0; e_vld[g] = 1'b0;
      end

      // R1: reset state
      repeat (3) @(negedge clk);
      compare();
      rst_n = 1'b1;
      @(negedge clk);
      req = "R1";
      acc0(0, 0, 2);

      // R6 / R10: unaligned buffer, base write loads the pointer
      req = "R6";
      wr(3, 3, 32'd1003);
      wr(3, 2, 32'd7);
      wr(3, 1, 32'd3);
      acc0(3, 3, 1);
      // R3: upward fold
      req = "R3";
      acc0(3, 3, 8);
      // R4: downward fold with a negative step
      req = "R4";
      wr(2, 1, 32'hFFFF_FFFE);
      acc0(3, 2, 8);
      // R10: steps of exactly +L and -L
      req = "R10";
      wr(4, 1, 32'd7);
      acc0(3, 4, 3);
      wr(5, 1, -32'sd7);
      acc0(3, 5, 3);

      // R5: zero length, linear across the top of the address space
      req = "R5";
      wr(6, 3, 32'hFFFF_FFFE);
      wr(7, 1, 32'd3);
      acc0(6, 7, 3);
      wr(7, 1, -32'sd5);
      acc0(6, 7, 3);

      // R8: both generators in the same cycle
      req = "R8";
      wr(9, 3, 32'd200);
      wr(9, 2, 32'd5);
      wr(10, 1, 32'd4);
      for (int k = 0; k < 6; k++) begin
         set_acc(0, 3, 3);
         set_acc(1, 1, 2);
         cycle();
      end

      // R7: secondary copy, then back to primary
      req = "R7";
      bank_sel_i = 1'b1;
      acc0(3, 3, 1);
      wr(3, 3, 32'd50);
      wr(3, 2, 32'd4);
      wr(3, 1, 32'd3);
      acc0(3, 3, 4);
      bank_sel_i = 1'b0;
      acc0(3, 3, 3);

      // R9: write collides with an access
      req = "R9";
      set_wr(3, 0, 32'd1004);
      set_acc(0, 3, 3);
      cycle();
      acc0(3, 3, 1);
      set_wr(3, 3, 32'd1001);
      set_acc(0, 3, 3);
      cycle();
      acc0(3, 3, 2);

      // R2: idle cycles hold the address and drop valid
      req = "R2";
      repeat (3) cycle();
      acc0(3, 3, 2);
      repeat (2) cycle();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule